// File: doc/BRIEF.md
# Prefixed Instruction Length Identifier

This block sits between instruction fetch and the decode stage. It takes 32-bit instruction words one at a time over a valid/ready input. For each instruction it decides whether the first word is a plain 32-bit operation or the prefix of a 64-bit operation. A plain word is passed on at once, with an all-zero 24-bit remap field. A prefix has its remap field stored, and the block then fetches exactly one more word, the suffix. The suffix is delivered together with the stored remap field in a single output transfer.

The block does no decoding beyond recognising the prefix. Prefix recognition is purely combinational. The only state is a three-state sequencer:

- `ST_FIRST` accepts the first word of an instruction.
- `ST_WAIT_SUFFIX` accepts the suffix of a prefixed instruction.
- `ST_HOLD` presents the assembled result until the decode stage takes it.

The transitions are:

- `ST_FIRST` goes to `ST_WAIT_SUFFIX` when the accepted word is a prefix.
- `ST_FIRST` goes to `ST_HOLD` when the accepted word is plain.
- `ST_WAIT_SUFFIX` goes to `ST_HOLD` when the suffix is accepted.
- `ST_HOLD` goes to `ST_FIRST` when the output handshake completes.
- A synchronous flush returns the sequencer from any state to `ST_FIRST`.

Top module: `insn_len_seq`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is a prefix when bits [31:26] equal 6'b000001 and bits [25:24] equal 2'b11. Accepting a prefix produces no output, and `in_ready` stays 1 so that the suffix can be accepted.
- R3: One cycle after a suffix is accepted, the block presents the following together: `out_valid`=1, `out_word` equal to the suffix, `out_remap` equal to bits [23:0] of the prefix, and `out_is_prefixed`=1.
- R4: One cycle after a plain word is accepted, the block presents the following together: `out_valid`=1, `out_word` equal to that word, `out_remap`=0, and `out_is_prefixed`=0.
- R5: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output field holds its value.
- R6: In the cycle after `out_valid` and `out_ready` are both 1, `out_valid` is 0 and `in_ready` is 1.
- R7: The suffix is never tested as a prefix. A prefix-pattern word that arrives as a suffix is delivered as the operation word of a prefixed instruction.
- R8: While `flush` is 1, `in_ready` and `out_valid` are 0. In the next cycle the block is waiting for a first word. Any stored remap field, half-fetched prefix or held result is discarded.
- R9: A word that matches only one of the two prefix fields (opcode or marker) is a plain 32-bit operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard, returns to first-word state |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Block can accept a fetch word |
| in_word | input | 32 | Fetched instruction word |
| out_valid | output | 1 | Assembled instruction valid |
| out_ready | input | 1 | Decode stage accepts the result |
| out_word | output | 32 | Plain word or suffix |
| out_remap | output | 24 | Remap field of the prefix, zero for plain words |
| out_is_prefixed | output | 1 | 1 for a 64-bit prefixed instruction |

## Verification
A flush can arrive in the same cycle as a fetch word. It can also arrive in the same cycle as the output handshake. The bench raises `flush` while `in_valid` carries a would-be suffix after a prefix has been latched. It checks that the word is refused in that cycle, with `in_ready` low. It then checks that the next plain word comes out with a zero remap field, which shows that the stale prefix was discarded. A flush is also applied while a result is held with `out_ready` high. The check there is that `out_valid` drops and that no duplicate result appears.

// File: rtl/insn_len_pkg.sv
package insn_len_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned REMAP_W = 24;

    typedef enum logic [1:0] {
        ST_FIRST       = 2'd0,
        ST_WAIT_SUFFIX = 2'd1,
        ST_HOLD        = 2'd2
    } seq_state_e;

endpackage

// File: rtl/prefix_detect.sv
module prefix_detect #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned REMAP_W   = 24,
    parameter int unsigned OPC_W     = 6,
    parameter int unsigned MARK_W    = 2,
    parameter logic [OPC_W-1:0]  OPC_VAL  = 6'b000001,
    parameter logic [MARK_W-1:0] MARK_VAL = 2'b11
) (
    input  logic [WORD_W-1:0]  word,
    output logic               is_prefix,
    output logic [REMAP_W-1:0] remap
);
    localparam int unsigned OPC_LSB  = WORD_W - OPC_W;
    localparam int unsigned MARK_LSB = OPC_LSB - MARK_W;

    logic opc_hit;
    logic mark_hit;

    always_comb begin
        opc_hit   = (word[OPC_LSB +: OPC_W] == OPC_VAL);
        mark_hit  = (word[MARK_LSB +: MARK_W] == MARK_VAL);
        is_prefix = opc_hit && mark_hit;
        remap     = word[REMAP_W-1:0];
    end
endmodule

// File: rtl/remap_hold.sv
module remap_hold #(
    parameter int unsigned REMAP_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               load,
    input  logic [REMAP_W-1:0] d,
    output logic [REMAP_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/insn_len_seq.sv
module insn_len_seq
    import insn_len_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_word,
    output logic [REMAP_W-1:0] out_remap,
    output logic               out_is_prefixed
);
    seq_state_e state_q, state_d;

    logic               word_is_prefix;
    logic [REMAP_W-1:0] word_remap;
    logic [REMAP_W-1:0] held_remap;
    logic               accept;
    logic               take_prefix;

    prefix_detect #(
        .WORD_W  (WORD_W),
        .REMAP_W (REMAP_W)
    ) u_detect (
        .word      (in_word),
        .is_prefix (word_is_prefix),
        .remap     (word_remap)
    );

    assign in_ready    = (state_q != ST_HOLD) && !flush;
    assign out_valid   = (state_q == ST_HOLD) && !flush;
    assign accept      = in_valid && in_ready;
    assign take_prefix = accept && (state_q == ST_FIRST) && word_is_prefix;

    remap_hold #(
        .REMAP_W (REMAP_W)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flush),
        .load  (take_prefix),
        .d     (word_remap),
        .q     (held_remap)
    );

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_FIRST;
        end else begin
            unique case (state_q)
                ST_FIRST: begin
                    if (accept) state_d = word_is_prefix ? ST_WAIT_SUFFIX : ST_HOLD;
                end
                ST_WAIT_SUFFIX: begin
                    if (accept) state_d = ST_HOLD;
                end
                ST_HOLD: begin
                    if (out_ready) state_d = ST_FIRST;
                end
                default: state_d = ST_FIRST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FIRST;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word        <= '0;
            out_remap       <= '0;
            out_is_prefixed <= 1'b0;
        end else if (accept) begin
            unique case (state_q)
                ST_FIRST: begin
                    if (!word_is_prefix) begin
                        out_word        <= in_word;
                        out_remap       <= '0;
                        out_is_prefixed <= 1'b0;
                    end
                end
                ST_WAIT_SUFFIX: begin
                    out_word        <= in_word;
                    out_remap       <= held_remap;
                    out_is_prefixed <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid || flush) && $stable(out_word)
            && $stable(out_remap) && $stable(out_is_prefixed));

    a_r5_no_input_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    a_r4_plain_zero_remap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_prefixed) |-> (out_remap == '0));

    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!in_ready && !out_valid));

    a_r8_flush_restart: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (flush || in_ready));

    a_r2_prefix_no_output: assert property (@(posedge clk) disable iff (!rst_n)
        (take_prefix && !flush) |=> (!out_valid && (flush || in_ready)));

endmodule

// File: tb/insn_len_seq_tb.sv
module insn_len_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_word;
    logic [23:0] out_remap;
    logic        out_is_prefixed;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    insn_len_seq u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .flush           (flush),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_word         (in_word),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_word        (out_word),
        .out_remap       (out_remap),
        .out_is_prefixed (out_is_prefixed)
    );

    typedef struct packed {
        logic        two;
        logic [31:0] w0;
        logic [31:0] w1;
        logic [31:0] xw;
        logic [23:0] xr;
        logic        xp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h7C22_1A14, 32'h0,          32'h7C22_1A14, 24'h0,      1'b0}, // R4
        '{1'b1, 32'h07AB_CDEF, 32'h3860_0005, 32'h3860_0005, 24'hABCDEF, 1'b1}, // R3
        '{1'b0, 32'h0612_3456, 32'h0,          32'h0612_3456, 24'h0,      1'b0}, // R9 marker miss
        '{1'b0, 32'h0B12_3456, 32'h0,          32'h0B12_3456, 24'h0,      1'b0}, // R9 opcode miss
        '{1'b1, 32'h0712_3456, 32'h07FF_FFFF, 32'h07FF_FFFF, 24'h123456, 1'b1}, // R7
        '{1'b1, 32'h0700_0000, 32'h1234_5678, 32'h1234_5678, 24'h0,      1'b1}  // R3 zero remap
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic feed(input logic [31:0] w, input string req);
        @(negedge clk);
        chk(in_ready == 1'b1, req, 64'(in_ready), 64'd1);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic take(input logic [31:0] xw, input logic [23:0] xr, input logic xp, input string req);
        @(negedge clk);
        chk(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
        chk(out_word == xw, req, 64'(out_word), 64'(xw));
        chk(out_remap == xr, req, 64'(out_remap), 64'(xr));
        chk(out_is_prefixed == xp, req, 64'(out_is_prefixed), 64'(xp));
        out_ready = 1'b1;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 64'h2);

        for (int i = 0; i < NV; i++) begin
            feed(VECS[i].w0, "R2");
            if (VECS[i].two) begin
                @(negedge clk);
                chk(out_valid == 1'b0, "R2", 64'(out_valid), 64'd0);
                feed(VECS[i].w1, "R7");
            end
            take(VECS[i].xw, VECS[i].xr, VECS[i].xp, "R3/R4/R7/R9");
            @(negedge clk);
            chk(out_valid == 1'b0 && in_ready == 1'b1, "R6", {in_ready, out_valid}, 64'h2);
        end

        // R5: backpressure holds the result and blocks input
        feed(32'h4E80_0020, "R5");
        in_valid = 1'b1;
        in_word  = 32'h0711_1111;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(in_ready == 1'b0, "R5", 64'(in_ready), 64'd0);
            chk(out_valid == 1'b1 && out_word == 32'h4E80_0020, "R5", 64'(out_word), 64'h4E80_0020);
        end
        in_valid = 1'b0;
        take(32'h4E80_0020, 24'h0, 1'b0, "R5");

        // R8: flush collides with a would-be suffix
        feed(32'h07AA_AAAA, "R8");
        @(negedge clk);
        flush    = 1'b1;
        in_valid = 1'b1;
        in_word  = 32'h3860_0009;
        #0;
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R8", {in_ready, out_valid}, 64'h0);
        @(posedge clk);
        #1 flush = 1'b0;
        in_valid = 1'b0;
        feed(32'h7C00_0000, "R8");
        take(32'h7C00_0000, 24'h0, 1'b0, "R8");

        // R8: flush collides with the output handshake
        feed(32'h6000_0000, "R8");
        @(negedge clk);
        flush     = 1'b1;
        out_ready = 1'b1;
        #0;
        chk(out_valid == 1'b0, "R8", 64'(out_valid), 64'd0);
        @(posedge clk);
        #1 flush = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R8", {in_ready, out_valid}, 64'h2);

        // R8: a fresh prefix after flush captures its own remap
        feed(32'h0765_4321, "R8");
        feed(32'h1111_2222, "R8");
        take(32'h1111_2222, 24'h654321, 1'b1, "R8");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule